// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects up to 32 external interrupt lines and one non-maskable line and hands the most urgent of them to a processor core. Software programs each line through a small register port. The port has four write-one-to-act registers: set enable, clear enable, set pending and clear pending. It also has a bank of priority words that give every line one of four urgency levels. A rising edge on an input line marks that line pending. The controller then offers the best pending, enabled request to the core as an exception number.

The core side uses a three-signal handshake. The controller raises `core_req` with an exception number. The core answers with `core_ack` when it enters the handler and with `core_ret` when the handler finishes. On acknowledge, the controller clears the request's pending bit and pushes its level onto a stack of active levels. On return, it pops that level. A new request is offered only if its level is strictly more urgent than the level on top of the stack. Requests that cannot preempt stay pending until the stack unwinds far enough. A global mask input holds back every request except the non-maskable one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to the set-enable register (byte offset 0x000) turns on the enable bit of every line whose data bit is 1. Zero bits leave their enable unchanged. Reading offset 0x000 or 0x080 returns the enable bits, with line n in bit n.
- R2: A write to the clear-enable register (offset 0x080) turns off the enable bit of every line whose data bit is 1. Zero bits have no effect.
- R3: Set-pending (offset 0x100) and clear-pending (offset 0x180) act the same way on the pending bits. Reading either offset returns the pending bits.
- R4: Priority words sit at offsets 0x300 + 4k. Word k holds lines 4k..4k+3, with line 4k+j in bits [8j+7:8j]. Only bits [8j+7:8j+6] of each field are stored, and all other bits read as 0. This gives the levels 0x00 (most urgent), 0x40, 0x80 and 0xC0.
- R5: A 0-to-1 transition on `irq_in[n]` sets pending bit n. A line held high does not set its pending bit again after that bit has been cleared.
- R6: Among pending, enabled lines, the one with the lowest priority value is offered. On a tie, the lowest line number wins. Line n is reported as exception number 16 + n. Read data and the request outputs are registered, so each appears one clock after the state it reflects.
- R7: A rising edge on `nmi_in` makes the non-maskable request pending. The enable bits cannot block it. It outranks every line and is reported as exception number 2.
- R8: While `mask_all` is 1, no line request is offered, but the non-maskable request still is.
- R9: When `core_ack` is high in a cycle where `core_req` is high, the offered request's pending bit is cleared and its level is pushed. `active_lvl` then shows that level, and `core_req` is low in the next cycle. The `active_lvl` codes are 0 for non-maskable, 1 to 4 for the levels 0x00 to 0xC0, and 5 for idle.
- R10: A request is offered only when its level code is strictly lower than `active_lvl`. A request of equal or lower urgency stays pending. While a non-maskable handler is active, nothing is offered.
- R11: `core_ret` pops the top active level. A request that was held back is offered once the new top level permits it.
- R12: After reset, all enable, pending and priority bits are 0, `core_req` is 0 and `active_lvl` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_in | input | NUM_IRQ | External interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| mask_all | input | 1 | Global mask for maskable requests |
| core_ack | input | 1 | Core takes the offered request |
| core_ret | input | 1 | Core leaves the current handler |
| core_req | output | 1 | A request is offered |
| core_excnum | output | 6 | Exception number of the offered request |
| active_lvl | output | 3 | Level code on top of the active stack |

## Verification
The bench targets tie-breaking between equal priorities, where a design that scans from the wrong end offers the higher-numbered line. It checks that the low priority bits written by software are dropped, where a design that stores them returns nonzero reads and misorders levels. A level-triggered capture would fire a held line again after its handler returns, and the bench checks that this does not happen. It probes equal-level arrival during an active handler, where a non-strict compare would nest a handler inside its peer. It also probes the non-maskable path under the global mask and during its own handler, where a wrong design either drops it or lets ordinary lines preempt it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef logic [2:0] lvl_t;
  localparam lvl_t LVL_NMI  = 3'd0;
  localparam lvl_t LVL_IDLE = 3'd5;
  localparam logic [5:0] EXC_NMI  = 6'd2;
  localparam logic [5:0] EXC_BASE = 6'd16;

  // 2-bit stored priority -> stack level code (1 = most urgent programmable)
  function automatic lvl_t prio_to_lvl(input logic [1:0] p);
    return lvl_t'({1'b0, p}) + lvl_t'(1);
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic [NUM_IRQ-1:0]      irq_in,
  input  logic [NUM_IRQ-1:0]      ack_clr,
  output logic [31:0]             rdata,
  output logic [NUM_IRQ-1:0]      en_q,
  output logic [NUM_IRQ-1:0]      pend_q,
  output logic [NUM_IRQ-1:0][1:0] prio_q
);
  localparam int NUM_WORDS = (NUM_IRQ + 3) / 4;

  logic [NUM_IRQ-1:0] irq_prev;
  logic [NUM_IRQ-1:0] wbits;
  logic [4:0]         word_idx;
  logic sel_low, wr_seten, wr_clren, wr_setpd, wr_clrpd, hit_prio;
  logic [31:0] rd_next;

  assign wbits    = wdata[NUM_IRQ-1:0];
  assign word_idx = addr[6:2];
  assign sel_low  = (addr[6:0] == 7'd0);
  assign wr_seten = wr_en && sel_low && (addr[ADDR_W-1:7] == 3'b000);
  assign wr_clren = wr_en && sel_low && (addr[ADDR_W-1:7] == 3'b001);
  assign wr_setpd = wr_en && sel_low && (addr[ADDR_W-1:7] == 3'b010);
  assign wr_clrpd = wr_en && sel_low && (addr[ADDR_W-1:7] == 3'b011);
  assign hit_prio = (addr[ADDR_W-1:7] == 3'b110) && (addr[1:0] == 2'b00)
                    && (int'(word_idx) < NUM_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      pend_q   <= '0;
      irq_prev <= '0;
    end else begin
      irq_prev <= irq_in;
      if (wr_seten) en_q <= en_q | wbits;
      else if (wr_clren) en_q <= en_q & ~wbits;
      pend_q <= (pend_q & ~ack_clr & ~(wr_clrpd ? wbits : '0))
                | (wr_setpd ? wbits : '0)
                | (irq_in & ~irq_prev);
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= 2'b00;
      else if (wr_en && hit_prio && int'(word_idx) == i / 4)
        prio_q[i] <= wdata[8*(i%4)+6 +: 2];
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_prio) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (int'(word_idx) == i / 4) rd_next[8*(i%4)+6 +: 2] = prio_q[i];
    end else if (sel_low) begin
      case (addr[ADDR_W-1:7])
        3'b000, 3'b001: rd_next[NUM_IRQ-1:0] = en_q;
        3'b010, 3'b011: rd_next[NUM_IRQ-1:0] = pend_q;
        default:        rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]      pend,
  input  logic [NUM_IRQ-1:0]      en,
  input  logic [NUM_IRQ-1:0][1:0] prio,
  input  logic                    nmi_pend,
  input  logic                    mask_all,
  input  lvl_t                    cur_lvl,
  output logic                    sel_valid,
  output logic                    sel_nmi,
  output logic [IDX_W-1:0]        sel_idx,
  output lvl_t                    sel_lvl,
  output logic [5:0]              sel_exc
);
  logic             found;
  logic [1:0]       best;
  logic [IDX_W-1:0] best_idx;
  logic             irq_ok, nmi_ok;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    best     = 2'b11;
    best_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && en[i] && (!found || prio[i] < best)) begin
        found    = 1'b1;
        best     = prio[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign nmi_ok    = nmi_pend && (cur_lvl != LVL_NMI);
  assign irq_ok    = found && !mask_all && (prio_to_lvl(best) < cur_lvl);
  assign sel_valid = nmi_ok || irq_ok;
  assign sel_nmi   = nmi_ok;
  assign sel_idx   = best_idx;
  assign sel_lvl   = nmi_ok ? LVL_NMI : prio_to_lvl(best);
  assign sel_exc   = nmi_ok ? EXC_NMI : EXC_BASE + 6'(best_idx);
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_ctrl_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t top_lvl
);
  lvl_t          stk [DEPTH];
  logic [SP_W-1:0] sp;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && int'(sp) < DEPTH) begin
      stk[sp] <= push_lvl;
      sp      <= sp + 1'b1;
    end else if (pop && sp != '0) begin
      sp <= sp - 1'b1;
    end
  end

  always_comb begin
    top_lvl = LVL_IDLE;
    for (int i = 0; i < DEPTH; i++)
      if (int'(sp) == i + 1) top_lvl = stk[i];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int ADDR_W      = 10,
  parameter int STACK_DEPTH = 5,
  localparam int IDX_W      = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               mask_all,
  input  logic               core_ack,
  input  logic               core_ret,
  output logic               core_req,
  output logic [5:0]         core_excnum,
  output logic [2:0]         active_lvl
);
  logic [NUM_IRQ-1:0]      en_q, pend_q, ack_clr;
  logic [NUM_IRQ-1:0][1:0] prio_q;
  logic                    nmi_prev, nmi_pend;
  logic                    sel_valid, sel_nmi;
  logic [IDX_W-1:0]        sel_idx, idx_q;
  lvl_t                    sel_lvl, lvl_q, top_lvl;
  logic [5:0]              sel_exc;
  logic                    req_q, nmi_q, ack_eff;

  assign ack_eff = core_ack && req_q;

  always_comb begin
    ack_clr = '0;
    if (ack_eff && !nmi_q) ack_clr[idx_q] = 1'b1;
  end

  irq_regfile #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .irq_in(irq_in), .ack_clr(ack_clr), .rdata(reg_rdata),
    .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      nmi_pend <= (nmi_pend && !(ack_eff && nmi_q)) || (nmi_in && !nmi_prev);
    end
  end

  irq_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
    .pend(pend_q), .en(en_q), .prio(prio_q), .nmi_pend(nmi_pend),
    .mask_all(mask_all), .cur_lvl(top_lvl), .sel_valid(sel_valid),
    .sel_nmi(sel_nmi), .sel_idx(sel_idx), .sel_lvl(sel_lvl), .sel_exc(sel_exc)
  );

  irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(ack_eff), .push_lvl(lvl_q),
    .pop(core_ret && !ack_eff), .top_lvl(top_lvl)
  );

  // registered offer; dropped for one cycle after an acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      nmi_q       <= 1'b0;
      idx_q       <= '0;
      lvl_q       <= LVL_IDLE;
      core_excnum <= '0;
    end else begin
      req_q       <= sel_valid && !ack_eff;
      nmi_q       <= sel_nmi;
      idx_q       <= sel_idx;
      lvl_q       <= sel_lvl;
      core_excnum <= sel_exc;
    end
  end

  assign core_req   = req_q;
  assign active_lvl = top_lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_IRQ = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       core_req,
  input logic [5:0] core_excnum,
  input logic       core_ack,
  input logic       core_ret,
  input logic       mask_all,
  input logic [2:0] active_lvl,
  input logic [2:0] req_lvl
);
  a_r6_excnum_range: assert property (@(posedge clk) disable iff (rst)
    core_req |-> (core_excnum == 6'd2) ||
                 (core_excnum >= 6'd16 && int'(core_excnum) < 16 + NUM_IRQ));

  a_r7_nmi_level: assert property (@(posedge clk) disable iff (rst)
    core_req && core_excnum == 6'd2 |-> req_lvl == 3'd0);

  a_r8_mask_only_nmi: assert property (@(posedge clk) disable iff (rst)
    core_req && $past(mask_all) |-> core_excnum == 6'd2);

  a_r9_push_level: assert property (@(posedge clk) disable iff (rst)
    core_ack && core_req |=> active_lvl == $past(req_lvl));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    core_ack && core_req |=> !core_req);

  a_r10_strict_preempt: assert property (@(posedge clk) disable iff (rst)
    core_req |-> req_lvl < active_lvl);

  a_r11_pop_less_urgent: assert property (@(posedge clk) disable iff (rst)
    core_ret && !(core_ack && core_req) && active_lvl != 3'd5
      |=> active_lvl > $past(active_lvl));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .core_req(core_req), .core_excnum(core_excnum),
  .core_ack(core_ack), .core_ret(core_ret), .mask_all(mask_all),
  .active_lvl(active_lvl), .req_lvl(lvl_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam logic [9:0] A_SETEN  = 10'h000;
  localparam logic [9:0] A_CLREN  = 10'h080;
  localparam logic [9:0] A_SETPD  = 10'h100;
  localparam logic [9:0] A_CLRPD  = 10'h180;
  localparam logic [9:0] A_PRIO0  = 10'h300;
  localparam logic [9:0] A_PRIO1  = 10'h304;

  // {en[7:0], pend[7:0], prio word0, prio word1, exp_req, exp_exc[5:0]}
  localparam int NV = 6;
  localparam logic [86:0] VEC [NV] = '{
    {8'h01, 8'h01, 32'h00000000, 32'h00000000, 1'b1, 6'd16},
    {8'hFF, 8'h0C, 32'h40800000, 32'h00000000, 1'b1, 6'd19},
    {8'hFF, 8'h30, 32'h00000000, 32'h00000000, 1'b1, 6'd20},
    {8'h0F, 8'hF0, 32'h00000000, 32'h00000000, 1'b0, 6'd0},
    {8'hFF, 8'h81, 32'h000000C0, 32'h00000000, 1'b1, 6'd23},
    {8'hFF, 8'h06, 32'h007FFF00, 32'h00000000, 1'b1, 6'd18}
  };

  logic        clk = 0, rst = 1, we = 0, nmi = 0, mask = 0, ack = 0, ret = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] irq = '0;
  logic        req;
  logic [5:0]  exc;
  logic [2:0]  lvl;
  int checks = 0, errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_in(irq), .nmi_in(nmi), .mask_all(mask),
    .core_ack(ack), .core_ret(ret), .core_req(req), .core_excnum(exc),
    .active_lvl(lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask
  task automatic pulse_ack(); @(negedge clk); ack = 1; @(negedge clk); ack = 0; endtask
  task automatic pulse_ret(); @(negedge clk); ret = 1; @(negedge clk); ret = 0; endtask
  task automatic clear_all();
    wr(A_CLRPD, 32'hFFFFFFFF); wr(A_CLREN, 32'hFFFFFFFF);
    wr(A_PRIO0, 0); wr(A_PRIO1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    chk("R12 req", {31'd0, req}, 0);
    chk("R12 lvl", {29'd0, lvl}, 5);
    rd(A_SETEN, d); chk("R12 enable", d, 0);
    rd(A_SETPD, d); chk("R12 pending", d, 0);

    // R1 / R2: enable set and clear
    wr(A_SETEN, 32'h000000A5); wr(A_SETEN, 0);
    rd(A_SETEN, d); chk("R1 set-enable", d, 32'h000000A5);
    wr(A_CLREN, 32'h00000005); wr(A_CLREN, 0);
    rd(A_CLREN, d); chk("R2 clear-enable", d, 32'h000000A0);

    // R3: pending set and clear
    wr(A_SETPD, 32'h00000300); wr(A_SETPD, 0);
    rd(A_CLRPD, d); chk("R3 set-pending", d, 32'h00000300);
    wr(A_CLRPD, 32'h00000100);
    rd(A_SETPD, d); chk("R3 clear-pending", d, 32'h00000200);

    // R4: priority storage
    wr(A_PRIO1, 32'hFFFFFFFF);
    rd(A_PRIO1, d); chk("R4 prio all ones", d, 32'hC0C0C0C0);
    wr(A_PRIO1, 32'h12345678);
    rd(A_PRIO1, d); chk("R4 prio low bits dropped", d, 32'h00004040);
    clear_all();

    // R6: arbitration table
    for (int v = 0; v < NV; v++) begin
      clear_all();
      wr(A_PRIO0, VEC[v][70:39]);
      wr(A_PRIO1, VEC[v][38:7]);
      wr(A_SETEN, {24'd0, VEC[v][86:79]});
      wr(A_SETPD, {24'd0, VEC[v][78:71]});
      settle();
      chk($sformatf("R6 vec%0d req", v), {31'd0, req}, {31'd0, VEC[v][6]});
      if (VEC[v][6]) chk($sformatf("R6 vec%0d exc", v), {26'd0, exc}, {26'd0, VEC[v][5:0]});
    end
    clear_all();

    // R5 / R9: edge capture, acknowledge, held line does not repend
    wr(A_SETEN, 32'h00000020);
    @(negedge clk); irq[5] = 1;
    settle();
    chk("R5 edge req", {31'd0, req}, 1);
    chk("R5 edge exc", {26'd0, exc}, 21);
    pulse_ack();
    chk("R9 req drops", {31'd0, req}, 0);
    chk("R9 level pushed", {29'd0, lvl}, 1);
    rd(A_SETPD, d); chk("R9 pending cleared", d, 0);
    pulse_ret(); settle();
    chk("R11 popped idle", {29'd0, lvl}, 5);
    chk("R5 held no repend", {31'd0, req}, 0);
    @(negedge clk); irq[5] = 0;
    @(negedge clk); irq[5] = 1;
    settle();
    chk("R5 second edge", {31'd0, req}, 1);
    pulse_ack(); pulse_ret();
    irq[5] = 0;
    clear_all();

    // R10 / R11: nesting
    wr(A_PRIO0, 32'h00008080);
    wr(A_SETEN, 32'h00000007);
    wr(A_SETPD, 32'h00000001); settle();
    chk("R10 first exc", {26'd0, exc}, 16);
    pulse_ack();
    chk("R10 level 0x80", {29'd0, lvl}, 3);
    wr(A_SETPD, 32'h00000002); settle();
    chk("R10 equal held", {31'd0, req}, 0);
    wr(A_SETPD, 32'h00000004); settle();
    chk("R10 higher preempts", {26'd0, exc}, 18);
    chk("R10 higher req", {31'd0, req}, 1);
    pulse_ack();
    chk("R10 nested level", {29'd0, lvl}, 1);
    pulse_ret(); settle();
    chk("R11 back to 0x80", {29'd0, lvl}, 3);
    chk("R11 equal still held", {31'd0, req}, 0);
    pulse_ret(); settle();
    chk("R11 held now offered", {31'd0, req}, 1);
    chk("R11 held exc", {26'd0, exc}, 17);
    pulse_ack(); pulse_ret();
    clear_all();

    // R7 / R8: global mask and non-maskable
    @(negedge clk); mask = 1;
    wr(A_SETEN, 32'h00000001); wr(A_SETPD, 32'h00000001); settle();
    chk("R8 masked", {31'd0, req}, 0);
    @(negedge clk); nmi = 1; settle();
    chk("R7 nmi req", {31'd0, req}, 1);
    chk("R7 nmi exc", {26'd0, exc}, 2);
    pulse_ack();
    chk("R7 nmi level", {29'd0, lvl}, 0);
    @(negedge clk); mask = 0; settle();
    chk("R10 nothing over nmi", {31'd0, req}, 0);
    pulse_ret(); settle();
    chk("R11 irq after nmi", {26'd0, exc}, 16);
    chk("R11 irq after nmi req", {31'd0, req}, 1);
    pulse_ack(); pulse_ret();
    nmi = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule